// File: doc/BRIEF.md
# Transmit VLAN Tag Inserter

This block sits in a byte-wide transmit stream, between frame assembly and the CRC stage. When a frame's own VLAN request is set and the global VLAN mode is on, the block adds a four-byte 802.1Q tag to the frame. The tag is placed right after the twelve address bytes. Its first two bytes are a programmable tag EtherType and its last two bytes are a 16-bit tag value supplied with the frame. Any other frame passes through byte for byte.

Both streams use valid/ready handshakes and carry start and end markers. While the block emits the tag bytes it lowers input ready and holds the pending input byte, so no data is lost. Each output byte also carries a flag that tells the downstream CRC stage whether to append an FCS. A tagged frame always asks for one. An untagged frame asks for one only when its insert-FCS request is set.

The per-frame requests, the tag value, the EtherType register and the mode bit are captured when the start byte is accepted. They stay fixed for the rest of that frame.

Top module: `vtag_inserter`

## Requirements
- R1: A tag is inserted only when the start byte's `in_vlan_req` is 1 and `vlan_mode_en` is 1 at that byte. Otherwise the output byte sequence equals the input byte sequence.
- R2: The four tag bytes follow the twelfth input byte of the frame. A frame that ends at or before its twelfth byte is never tagged.
- R3: Output bytes 13 and 14 of a tagged frame are `tag_etype[15:8]` followed by `tag_etype[7:0]`.
- R4: Output bytes 15 and 16 of a tagged frame are `in_tag[15:8]` followed by `in_tag[7:0]`, using the value presented with the start byte. Later changes to `in_tag`, `tag_etype` or `vlan_mode_en` within the frame have no effect on that frame.
- R5: `out_fcs_append` is 1 on every byte of a frame when that frame's VLAN request and mode are both 1. Otherwise it equals the start byte's `in_fcs_req`. It is constant across the frame.
- R6: `out_sof` marks only the first output byte of a frame. `out_eof` marks only the last output byte, which in a tagged frame comes four bytes later than in the input.
- R7: While tag bytes are emitted, `in_ready` is 0. The held input byte is delivered afterwards, and no byte is lost or repeated.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output byte and markers stay unchanged and `in_ready` is 0.
- R9: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vlan_mode_en | input | 1 | Global VLAN mode enable |
| tag_etype | input | 16 | Programmable tag EtherType |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_vlan_req | input | 1 | Frame requests tag insertion (read with start byte) |
| in_fcs_req | input | 1 | Frame requests FCS (read with start byte) |
| in_tag | input | 16 | Tag control value (read with start byte) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte of frame |
| out_eof | output | 1 | Last output byte of frame |
| out_fcs_append | output | 1 | Downstream CRC stage should append FCS |

## Verification
The bench uses the default parameters: 8-bit bytes, a 16-bit tag field and a 12-byte address header. With these values it can drive frames of 1, 12 and 13 bytes, which sit on either side of the insertion point, as well as longer frames of up to 40 bytes. Random output stalls overlap the tag phase, and the EtherType, mode and tag inputs are scrambled in the middle of frames to show that only the start-byte values count.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
    typedef enum logic [1:0] {
        PH_HEAD = 2'd0,
        PH_TAG  = 2'd1,
        PH_BODY = 2'd2
    } phase_e;
endpackage

// File: rtl/vtag_ctx_reg.sv
module vtag_ctx_reg #(
    parameter int FIELD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] etype_in,
    input  logic [FIELD_W-1:0] tag_in,
    input  logic               ins_in,
    input  logic               fcs_in,
    output logic [FIELD_W-1:0] etype_cur,
    output logic [FIELD_W-1:0] tag_cur,
    output logic               ins_cur,
    output logic               fcs_cur
);
    typedef struct packed {
        logic [FIELD_W-1:0] etype;
        logic [FIELD_W-1:0] tag;
        logic               ins;
        logic               fcs;
    } ctx_t;

    ctx_t ctx_d, ctx_q, live;

    always_comb begin
        live.etype = etype_in;
        live.tag   = tag_in;
        live.ins   = ins_in;
        live.fcs   = fcs_in;
        ctx_d      = load ? live : ctx_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // The start byte itself already sees its own context.
    assign etype_cur = ctx_d.etype;
    assign tag_cur   = ctx_d.tag;
    assign ins_cur   = ctx_d.ins;
    assign fcs_cur   = ctx_d.fcs;
endmodule

// File: rtl/vtag_tag_mux.sv
module vtag_tag_mux #(
    parameter int FIELD_W = 16,
    parameter int DATA_W  = 8,
    localparam int WORD_W = 2 * FIELD_W,
    localparam int N_BYTES = WORD_W / DATA_W,
    localparam int IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
    input  logic [FIELD_W-1:0] etype,
    input  logic [FIELD_W-1:0] tag,
    input  logic [IDX_W-1:0]   idx,
    output logic [DATA_W-1:0]  byte_out
);
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] slice [N_BYTES];

    assign word = {etype, tag};

    // Most significant byte leaves first.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_slice
        assign slice[k] = word[WORD_W-1-k*DATA_W -: DATA_W];
    end

    always_comb begin
        byte_out = slice[0];
        for (int k = 0; k < N_BYTES; k++) begin
            if (idx == IDX_W'(k)) begin
                byte_out = slice[k];
            end
        end
    end
endmodule

// File: rtl/vtag_inserter.sv
module vtag_inserter #(
    parameter int DATA_W     = 8,
    parameter int FIELD_W    = 16,
    parameter int ADDR_BYTES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vlan_mode_en,
    input  logic [FIELD_W-1:0] tag_etype,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_sof,
    input  logic               in_eof,
    input  logic               in_vlan_req,
    input  logic               in_fcs_req,
    input  logic [FIELD_W-1:0] in_tag,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_sof,
    output logic               out_eof,
    output logic               out_fcs_append
);
    import vtag_pkg::*;

    localparam int TAG_BYTES = (2 * FIELD_W) / DATA_W;
    localparam int IDX_W     = (TAG_BYTES > 1) ? $clog2(TAG_BYTES) : 1;
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [IDX_W-1:0]   tidx;
        logic               ov;
        logic [DATA_W-1:0]  od;
        logic               osof;
        logic               oeof;
        logic               ofcs;
    } st_t;

    st_t st_d, st_q;

    logic               adv;
    logic               take;
    logic               cap;
    logic [FIELD_W-1:0] etype_cur;
    logic [FIELD_W-1:0] tag_cur;
    logic               ins_cur;
    logic               fcs_cur;
    logic [DATA_W-1:0]  tag_byte;

    assign adv      = !st_q.ov || out_ready;
    assign in_ready = adv && (st_q.phase != PH_TAG);
    assign take     = in_valid && in_ready;
    assign cap      = take && in_sof;

    vtag_ctx_reg #(
        .FIELD_W (FIELD_W)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap),
        .etype_in  (tag_etype),
        .tag_in    (in_tag),
        .ins_in    (in_vlan_req && vlan_mode_en),
        .fcs_in    ((in_vlan_req && vlan_mode_en) || in_fcs_req),
        .etype_cur (etype_cur),
        .tag_cur   (tag_cur),
        .ins_cur   (ins_cur),
        .fcs_cur   (fcs_cur)
    );

    vtag_tag_mux #(
        .FIELD_W (FIELD_W),
        .DATA_W  (DATA_W)
    ) u_mux (
        .etype    (etype_cur),
        .tag      (tag_cur),
        .idx      (st_q.tidx),
        .byte_out (tag_byte)
    );

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.ov = 1'b0;
        end
        case (st_q.phase)
            PH_TAG: begin
                if (adv) begin
                    st_d.ov   = 1'b1;
                    st_d.od   = tag_byte;
                    st_d.osof = 1'b0;
                    st_d.oeof = 1'b0;
                    st_d.ofcs = fcs_cur;
                    st_d.tidx = st_q.tidx + 1'b1;
                    if (st_q.tidx == IDX_W'(TAG_BYTES - 1)) begin
                        st_d.phase = PH_BODY;
                        st_d.tidx  = '0;
                    end
                end
            end
            default: begin
                if (take) begin
                    st_d.ov   = 1'b1;
                    st_d.od   = in_data;
                    st_d.osof = in_sof;
                    st_d.oeof = in_eof;
                    st_d.ofcs = fcs_cur;
                    if (in_eof) begin
                        st_d.phase = PH_HEAD;
                        st_d.cnt   = '0;
                    end else if (st_q.phase == PH_HEAD) begin
                        if (st_q.cnt == CNT_W'(ADDR_BYTES - 1)) begin
                            st_d.cnt   = '0;
                            st_d.tidx  = '0;
                            st_d.phase = ins_cur ? PH_TAG : PH_BODY;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HEAD, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid      = st_q.ov;
    assign out_data       = st_q.od;
    assign out_sof        = st_q.osof;
    assign out_eof        = st_q.oeof;
    assign out_fcs_append = st_q.ofcs;
endmodule

// File: rtl/vtag_inserter_chk.sv
module vtag_inserter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sof,
    input logic              out_eof,
    input logic              out_fcs_append
);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eof)));

    // R8
    stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5
    fcs_frame_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eof) |=> $stable(out_fcs_append));

    // R7
    tag_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready && !(out_valid && !out_ready))
        |=> (out_valid && !out_sof && !out_eof));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);
endmodule

bind vtag_inserter vtag_inserter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_data       (out_data),
    .out_sof        (out_sof),
    .out_eof        (out_eof),
    .out_fcs_append (out_fcs_append)
);

// File: tb/vtag_inserter_tb.sv
module vtag_inserter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vlan_mode_en = 1'b0;
    logic [15:0] tag_etype = 16'h8100;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_vlan_req = 1'b0;
    logic        in_fcs_req = 1'b0;
    logic [15:0] in_tag = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic        out_sof;
    logic        out_eof;
    logic        out_fcs_append;

    always #5 clk = ~clk;

    vtag_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .vlan_mode_en(vlan_mode_en), .tag_etype(tag_etype),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_vlan_req(in_vlan_req), .in_fcs_req(in_fcs_req), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_fcs_append(out_fcs_append)
    );

    typedef struct {
        logic [7:0] d;
        bit         sof;
        bit         eof;
        bit         fcs;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_bad  = 0;
    bit   stall_on = 1'b0;
    bit   scramble = 1'b0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Output ready pattern, changed away from the clock edge.
    initial begin
        forever begin
            @(posedge clk); #2;
            out_ready = stall_on ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    // Monitor: compare every accepted output byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && out_valid && !out_ready) begin
            check(!in_ready, "R8", "in_ready during stall", in_ready, 0);
        end
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "unexpected byte", out_data, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_data == e.d, e.req, "data", out_data, e.d);
                check(out_sof == e.sof && out_eof == e.eof, "R6", "sof/eof",
                      {out_sof, out_eof}, {e.sof, e.eof});
                check(out_fcs_append == e.fcs, "R5", "fcs flag", out_fcs_append, e.fcs);
            end
        end
    end

    task automatic put_byte(input logic [7:0] d, input bit sof, input bit eof,
                            input bit vreq, input bit freq, input logic [15:0] tag);
        in_valid = 1'b1;
        in_data  = d;
        in_sof   = sof;
        in_eof   = eof;
        if (sof) begin
            in_vlan_req = vreq;
            in_fcs_req  = freq;
            in_tag      = tag;
        end else begin
            in_vlan_req = 1'($urandom);
            in_fcs_req  = 1'($urandom);
            in_tag      = 16'($urandom);
        end
        forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input int len, input bit vreq, input bit freq);
        logic [15:0] tag;
        logic [15:0] et_save;
        bit          mode_save;
        bit          ins;
        bit          fcs;
        exp_t        e;
        logic [7:0]  bytes[];
        tag       = 16'($urandom);
        et_save   = tag_etype;
        mode_save = vlan_mode_en;
        ins       = vreq && vlan_mode_en && (len > 12);
        fcs       = (vreq && vlan_mode_en) || freq;
        bytes     = new[len];
        for (int i = 0; i < len; i++) bytes[i] = 8'($urandom);
        for (int i = 0; i < len; i++) begin
            e.d = bytes[i]; e.sof = (i == 0); e.eof = (i == len - 1); e.fcs = fcs;
            e.req = (i < 12) ? "R2" : (ins ? "R7" : "R1");
            exp_q.push_back(e);
            if (i == 11 && ins) begin
                e.sof = 1'b0; e.eof = 1'b0;
                e.d = tag_etype[15:8]; e.req = "R3"; exp_q.push_back(e);
                e.d = tag_etype[7:0];  e.req = "R3"; exp_q.push_back(e);
                e.d = tag[15:8];       e.req = "R4"; exp_q.push_back(e);
                e.d = tag[7:0];        e.req = "R4"; exp_q.push_back(e);
            end
        end
        for (int i = 0; i < len; i++) begin
            put_byte(bytes[i], i == 0, i == len - 1, vreq, freq, tag);
            if (i == 0 && scramble) begin
                tag_etype    = ~tag_etype;
                vlan_mode_en = ~vlan_mode_en;
            end
            if ($urandom_range(0, 5) == 0) begin
                @(posedge clk); #2;
            end
        end
        tag_etype    = et_save;
        vlan_mode_en = mode_save;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        @(posedge clk); #2;

        vlan_mode_en = 1'b1; tag_etype = 16'h88A8;
        send_frame(20, 1'b1, 1'b0);   // R1 tagged, R5 forced FCS
        send_frame(16, 1'b0, 1'b1);   // R1 untagged, FCS by request
        send_frame(16, 1'b0, 1'b0);   // R5 no FCS
        vlan_mode_en = 1'b0;
        send_frame(18, 1'b1, 1'b0);   // R1 mode off: no tag, no FCS
        vlan_mode_en = 1'b1; tag_etype = 16'h8100;
        send_frame(12, 1'b1, 1'b0);   // R2 short frame untouched
        send_frame(1, 1'b1, 1'b1);    // R2 single byte
        send_frame(13, 1'b1, 1'b0);   // R2 R6 tag then final byte

        stall_on = 1'b1;
        scramble = 1'b1;              // R4 later changes ignored
        for (int f = 0; f < 40; f++) begin
            vlan_mode_en = 1'($urandom);
            tag_etype    = 16'($urandom);
            send_frame($urandom_range(1, 40), 1'($urandom), 1'($urandom));
        end
        stall_on = 1'b0;
        repeat (20) @(posedge clk);
        check(exp_q.size() == 0, "R7", "bytes left undelivered", exp_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) check(1'b0, "R7", "watchdog expired", 0, 1);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule